// File: doc/BRIEF.md
# Range-Based External Wait-State Generator

This block decides how long each external memory or I/O access stays on the bus. Every access falls into one of five address ranges. The range comes from the address space of the access and the top bit of its address. Each range has its own programmed count of 0 to 7 wait states. A single control bit doubles every count, so one access can be stretched by up to 14 cycles.

When the core issues an access, the block accepts the request, latches the count for that range, and holds a stall line to the core while the count runs down. Once the count is spent, a ready input from the external device can hold the access for as long as the device needs. When the access ends, a one-cycle completion strobe is raised.

If every range is programmed to zero waits, the block turns off the enable of its count register. The enable is exported, so the power saving can be seen at the ports.

Top module: `wait_state_gen`

## Requirements
- R1: After reset, stall and done are low and the count enable is high. An access made before any configuration write receives 7 wait states, with no doubling.
- R2: The wait register write data holds one 3-bit field per range; range k uses bits [3k+2:3k]. The range is chosen from the access as follows. Space 0 (program) selects range 0 when the address MSB is 0 and range 1 when it is 1. Space 1 (data) selects range 2 when the MSB is 0 and range 3 when it is 1. Spaces 2 and 3 (I/O) select range 4.
- R3: A request is accepted on a rising edge while the block is idle. Stall is high for exactly N+1 cycles after that edge, where N is the effective wait count and ready is high. Done is high for exactly one cycle, in the first cycle after stall falls.
- R4: When the multiplier bit is 1, the effective wait count is twice the range's field. When it is 0, the count equals the field. The maximum is 14.
- R5: If ready is low once the count has reached zero, stall stays high. Completion comes on the first edge at which ready is seen high.
- R6: Configuration writes made during an access leave that access's length unchanged. They apply from the next accepted access onward.
- R7: The count enable output is low whenever all five fields are zero and no count is left in progress. It is high otherwise. An access made with all fields zero stalls for exactly one cycle.
- R8: A request raised while an access is in progress or completing is ignored. The block returns to idle after done and does not start another access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_cfg_we | input | 1 | Write strobe for the per-range wait fields |
| wait_cfg_data | input | 15 | Five 3-bit wait fields, range k at bits [3k+2:3k] |
| mul_cfg_we | input | 1 | Write strobe for the multiplier bit |
| mul_cfg_data | input | 1 | Multiplier bit: 1 doubles all wait counts |
| acc_req | input | 1 | Access request from the core |
| acc_space | input | 2 | Access space: 0 program, 1 data, 2 or 3 I/O |
| acc_addr_msb | input | 1 | Most significant address bit of the access |
| ext_ready | input | 1 | External device ready |
| stall | output | 1 | Core stall while the access is being stretched |
| done | output | 1 | One-cycle access completion strobe |
| cnt_clk_on | output | 1 | Enable of the wait counter register (low means gated off) |

## Verification
The hardest case to reach is a configuration write that arrives while a count is still running. The ports show nothing about the latched count, so the only evidence is the length of the stall. The bench sets a long count, starts an access, and writes all fields to zero two cycles into the stall. It then checks that the full original stall length is kept and that the count enable stays high until that count finishes. Ready held low past the end of the count, and a request pulse raised during an access, are both driven from inside the stall-counting loop. This places them at exact cycle offsets from acceptance.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  localparam int NUM_RANGES = 5;
  localparam int FIELD_W    = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_t;

  typedef enum logic [2:0] {
    RNG_PROG_LO = 3'd0,
    RNG_PROG_HI = 3'd1,
    RNG_DATA_LO = 3'd2,
    RNG_DATA_HI = 3'd3,
    RNG_IO      = 3'd4
  } range_t;
endpackage

// File: rtl/wsg_cfg_regs.sv
module wsg_cfg_regs #(
  parameter int NR = wsg_pkg::NUM_RANGES,
  parameter int FW = wsg_pkg::FIELD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wait_we,
  input  logic [NR*FW-1:0] wait_wdata,
  input  logic             mul_we,
  input  logic             mul_wdata,
  output logic [NR*FW-1:0] fields,
  output logic             mul,
  output logic             any_nonzero
);
  logic [NR*FW-1:0] fields_nxt;
  logic             mul_nxt;
  logic [NR-1:0]    fld_nz;

  always_comb begin
    fields_nxt = fields;
    mul_nxt    = mul;
    if (wait_we) fields_nxt = wait_wdata;
    if (mul_we)  mul_nxt    = mul_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields <= '1;
      mul    <= 1'b0;
    end else begin
      fields <= fields_nxt;
      mul    <= mul_nxt;
    end
  end

  for (genvar k = 0; k < NR; k++) begin : g_nz
    assign fld_nz[k] = |fields[k*FW +: FW];
  end
  assign any_nonzero = |fld_nz;

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wait_we |=> fields == $past(wait_wdata)); // R2
endmodule

// File: rtl/wsg_range_sel.sv
module wsg_range_sel #(
  parameter int NR = wsg_pkg::NUM_RANGES,
  parameter int FW = wsg_pkg::FIELD_W,
  localparam int CW = FW + 1
) (
  input  logic [1:0]       space,
  input  logic             addr_msb,
  input  logic [NR*FW-1:0] fields,
  input  logic             mul,
  output logic [CW-1:0]    load_val
);
  import wsg_pkg::*;
  range_t        rng;
  logic [FW-1:0] fld;

  always_comb begin
    unique case (space)
      2'd0:    rng = addr_msb ? RNG_PROG_HI : RNG_PROG_LO;
      2'd1:    rng = addr_msb ? RNG_DATA_HI : RNG_DATA_LO;
      default: rng = RNG_IO;
    endcase
  end

  always_comb begin
    fld = '0;
    for (int k = 0; k < NR; k++) begin
      if (int'(rng) == k) fld = fields[k*FW +: FW];
    end
  end

  assign load_val = mul ? {fld, 1'b0} : {1'b0, fld};

  always_comb begin
    AST_LOAD_LIMIT: assert (load_val <= CW'(2 * ((1 << FW) - 1))); // R4
  end
endmodule

// File: rtl/wsg_seq.sv
module wsg_seq #(
  parameter int CW = wsg_pkg::FIELD_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          ready,
  input  logic [CW-1:0] load_val,
  input  logic          any_nonzero,
  output logic          stall,
  output logic          done,
  output logic          clk_on
);
  import wsg_pkg::*;
  seq_state_t    state, state_nxt;
  logic [CW-1:0] cnt, cnt_nxt;

  assign clk_on = any_nonzero || (cnt != '0);

  always_comb begin
    state_nxt = state;
    cnt_nxt   = cnt;
    unique case (state)
      SEQ_IDLE: if (req) begin
        state_nxt = SEQ_WAIT;
        cnt_nxt   = load_val;
      end
      SEQ_WAIT: begin
        if (cnt != '0)  cnt_nxt   = cnt - 1'b1;
        else if (ready) state_nxt = SEQ_DONE;
      end
      default: state_nxt = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEQ_IDLE;
    else        state <= state_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clk_on) cnt <= cnt_nxt;
  end

  assign stall = (state == SEQ_WAIT);
  assign done  = (state == SEQ_DONE);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !stall); // R3
  AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    stall && cnt != '0 |=> stall && cnt == $past(cnt) - 1'b1); // R3
  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    stall && cnt == '0 && !ready |=> stall); // R5
  AST_GATED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_on |=> $stable(cnt)); // R7
  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> state == SEQ_IDLE); // R8
endmodule

// File: rtl/wait_state_gen.sv
module wait_state_gen #(
  parameter int NR = wsg_pkg::NUM_RANGES,
  parameter int FW = wsg_pkg::FIELD_W,
  localparam int CW = FW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wait_cfg_we,
  input  logic [NR*FW-1:0] wait_cfg_data,
  input  logic             mul_cfg_we,
  input  logic             mul_cfg_data,
  input  logic             acc_req,
  input  logic [1:0]       acc_space,
  input  logic             acc_addr_msb,
  input  logic             ext_ready,
  output logic             stall,
  output logic             done,
  output logic             cnt_clk_on
);
  logic [NR*FW-1:0] fields;
  logic             mul;
  logic             any_nz;
  logic [CW-1:0]    load_val;

  wsg_cfg_regs #(.NR(NR), .FW(FW)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wait_we(wait_cfg_we), .wait_wdata(wait_cfg_data),
    .mul_we(mul_cfg_we), .mul_wdata(mul_cfg_data),
    .fields(fields), .mul(mul), .any_nonzero(any_nz)
  );

  wsg_range_sel #(.NR(NR), .FW(FW)) u_sel (
    .space(acc_space), .addr_msb(acc_addr_msb),
    .fields(fields), .mul(mul), .load_val(load_val)
  );

  wsg_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req(acc_req), .ready(ext_ready),
    .load_val(load_val), .any_nonzero(any_nz),
    .stall(stall), .done(done), .clk_on(cnt_clk_on)
  );

  AST_STALL_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall && done)); // R3
endmodule

// File: tb/wait_state_gen_test.sv
module wait_state_gen_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wait_cfg_we, mul_cfg_we, mul_cfg_data;
  logic [14:0] wait_cfg_data;
  logic        acc_req, acc_addr_msb, ext_ready;
  logic [1:0]  acc_space;
  logic        stall, done, cnt_clk_on;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wait_state_gen uut (
    .clk(clk), .rst_n(rst_n),
    .wait_cfg_we(wait_cfg_we), .wait_cfg_data(wait_cfg_data),
    .mul_cfg_we(mul_cfg_we), .mul_cfg_data(mul_cfg_data),
    .acc_req(acc_req), .acc_space(acc_space), .acc_addr_msb(acc_addr_msb),
    .ext_ready(ext_ready),
    .stall(stall), .done(done), .cnt_clk_on(cnt_clk_on)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_waits(input logic [14:0] d);
    wait_cfg_data = d; wait_cfg_we = 1'b1;
    @(negedge clk); wait_cfg_we = 1'b0;
  endtask

  task automatic write_mul(input logic m);
    mul_cfg_data = m; mul_cfg_we = 1'b1;
    @(negedge clk); mul_cfg_we = 1'b0;
  endtask

  // One access; counts stall cycles and checks the done pulse.
  task automatic access(input logic [1:0] sp, input logic msb, input int n_exp,
                        input int hold, input bit mid_zero, input bit req_glitch,
                        input string tag);
    int n = 0;
    acc_space = sp; acc_addr_msb = msb;
    ext_ready = (hold == 0);
    acc_req = 1'b1;
    @(negedge clk);
    acc_req = 1'b0;
    while (stall && n < 100) begin
      n++;
      if (hold > 0 && n == n_exp + 1 + hold) ext_ready = 1'b1;
      if (mid_zero && n == 2) begin wait_cfg_data = '0; wait_cfg_we = 1'b1; end
      if (mid_zero && n == 3) wait_cfg_we = 1'b0;
      if (mid_zero && n == 3) check(cnt_clk_on == 1'b1, {tag, " R6 enable held"}, cnt_clk_on, 1);
      if (req_glitch && n == 2) acc_req = 1'b1;
      if (req_glitch && n == 3) acc_req = 1'b0;
      @(negedge clk);
    end
    wait_cfg_we = 1'b0; acc_req = 1'b0; ext_ready = 1'b1;
    check(n == n_exp + 1 + hold, {tag, " R3 stall length"}, n, n_exp + 1 + hold);
    check(done == 1'b1, {tag, " R3 done pulse"}, done, 1);
    @(negedge clk);
    check(done == 1'b0 && stall == 1'b0, {tag, " R3 idle after done"}, {done, stall}, 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wait_cfg_we = 1'b0; wait_cfg_data = '0;
    mul_cfg_we = 1'b0; mul_cfg_data = 1'b0;
    acc_req = 1'b0; acc_space = 2'd0; acc_addr_msb = 1'b0; ext_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(stall == 1'b0, "R1 stall at reset", stall, 0);
    check(done == 1'b0, "R1 done at reset", done, 0);
    check(cnt_clk_on == 1'b1, "R1 enable at reset", cnt_clk_on, 1);
    access(2'd0, 1'b0, 7, 0, 1'b0, 1'b0, "R1 default");
    access(2'd2, 1'b1, 7, 0, 1'b0, 1'b0, "R1 default io");
    // R2 ranges 0..4 get 1..5
    write_waits({3'd5, 3'd4, 3'd3, 3'd2, 3'd1});
    access(2'd0, 1'b0, 1, 0, 1'b0, 1'b0, "R2 prog lo");
    access(2'd0, 1'b1, 2, 0, 1'b0, 1'b0, "R2 prog hi");
    access(2'd1, 1'b0, 3, 0, 1'b0, 1'b0, "R2 data lo");
    access(2'd1, 1'b1, 4, 0, 1'b0, 1'b0, "R2 data hi");
    access(2'd2, 1'b0, 5, 0, 1'b0, 1'b0, "R2 io");
    access(2'd3, 1'b1, 5, 0, 1'b0, 1'b0, "R2 io alt");
    // R4 multiplier
    write_mul(1'b1);
    access(2'd2, 1'b0, 10, 0, 1'b0, 1'b0, "R4 doubled io");
    access(2'd0, 1'b0, 2, 0, 1'b0, 1'b0, "R4 doubled prog lo");
    write_waits({3'd7, 3'd4, 3'd3, 3'd2, 3'd1});
    access(2'd2, 1'b0, 14, 0, 1'b0, 1'b0, "R4 maximum");
    write_mul(1'b0);
    // R5 ready extension
    access(2'd0, 1'b1, 2, 3, 1'b0, 1'b0, "R5 ready hold");
    access(2'd1, 1'b0, 3, 1, 1'b0, 1'b0, "R5 ready hold one");
    // R8 request during access ignored
    access(2'd1, 1'b1, 4, 0, 1'b0, 1'b1, "R8 req glitch");
    @(negedge clk);
    check(stall == 1'b0, "R8 no extra access", stall, 0);
    // R6 mid-access config write keeps the 7-wait length
    access(2'd2, 1'b0, 7, 0, 1'b1, 1'b0, "R6 mid write");
    // R7 all fields now zero
    check(cnt_clk_on == 1'b0, "R7 enable off", cnt_clk_on, 0);
    access(2'd0, 1'b0, 0, 0, 1'b0, 1'b0, "R7 zero waits");
    write_mul(1'b1);
    access(2'd2, 1'b0, 0, 0, 1'b0, 1'b0, "R7 zero doubled");
    check(cnt_clk_on == 1'b0, "R7 enable still off", cnt_clk_on, 0);
    write_waits({3'd0, 3'd0, 3'd1, 3'd0, 3'd0});
    check(cnt_clk_on == 1'b1, "R7 enable back on", cnt_clk_on, 1);
    access(2'd1, 1'b0, 2, 0, 1'b0, 1'b0, "R7 reenabled");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule